// File: doc/BRIEF.md
# Byte-Port Packet Network Device

This block is the register slice of a simple network device that moves frames one byte at a time. It sits on a 32-bit memory-mapped bus. The bus has separate read and write strobes and a word address that covers a 64-byte window. Software identifies the device from a fixed 64-bit signature. It then drains received frames through a byte-wide data port and pushes outgoing frames through a second byte-wide data port. Counters track progress in both directions.

On the device side, incoming bytes arrive on a valid/last stream. The stream is held off while an unacknowledged frame is waiting. Each accepted transmit byte leaves on an output stream one cycle after the host writes it. A single interrupt line reports transmit completion, a waiting receive frame, and a software-raised test interrupt.

Register word indices (byte offset = index × 4):

| Index | Register |
|---|---|
| 0 | identifier, low word |
| 1 | identifier, high word |
| 2 | busy |
| 3 | receive count |
| 4 | transmit count |
| 5 | interrupt control |
| 6 | interrupt info |
| 7 | receive data |
| 8 | transmit data |

Top module: `bytenet_dev`

## Requirements
- R1: Index 0 reads 32'h54454E42 and index 1 reads 32'h31564544. Together they form the 64-bit signature "BNETDEV" followed by the ASCII version digit (default 1), with the first character in bits 7:0. Writes to these indices change nothing.
- R2: Busy (index 2, bit 0) reads 1 in two cases: a receive frame has started but its last byte has not arrived, or the transmit count is nonzero. Otherwise it reads 0.
- R3: A byte is accepted when rx_valid_i is high and rx_ready_o is high. The byte that carries rx_last_i ends the frame. On that edge the receive count (index 3) loads the number of bytes stored, and interrupt control bit 1 (receive available) sets. While bit 1 is set, rx_ready_o is low and incoming bytes are dropped.
- R4: A read of index 7 returns the next stored byte in arrival order in bits 7:0, with the upper bits zero, and decrements the receive count. When the count is zero, the read returns 0 and the count stays 0.
- R5: Only the first RX_DEPTH (default 2048) bytes of a frame are stored. A longer frame loads a receive count of RX_DEPTH.
- R6: A write to index 4 loads the transmit count, clamped to MAX_BYTES (default 65536). Each write to index 8 while the count is nonzero does three things on the next cycle: it drives tx_valid_o with wdata_i[7:0] on tx_data_o, it decrements the count, and it raises tx_last_o if the byte was the final one.
- R7: A write to index 8 while the transmit count is zero produces no output byte and leaves the count at zero.
- R8: Interrupt control bit 0 (transmit done) sets when the transmit count reaches zero through a data write. Writing 1 to bit 0 or to bit 1 of index 5 clears that bit. Writing 0 to either bit leaves it unchanged.
- R9: Interrupt control bit 31 (test) sets on a write to index 5 with bit 31 high. It clears on a write of the all-zero value, and it clears after any read of index 5; that read still returns 1 in bit 31. A nonzero write with bit 31 low leaves it unchanged.
- R10: irq_o is high exactly when at least one of bits 0, 1 or 31 of interrupt control is set.
- R11: Index 6 reads the INFO_WORD parameter (default 32'h00000102). Indices 9 to 15 read 0. Writes to indices 2, 3, 6, 7 and 9 to 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Bus read strobe |
| wr_i | input | 1 | Bus write strobe |
| addr_i | input | 4 | Word index inside the 64-byte window |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Bus read data, valid in the cycle of rd_i |
| rx_valid_i | input | 1 | Incoming byte valid |
| rx_data_i | input | 8 | Incoming byte |
| rx_last_i | input | 1 | Incoming byte ends the frame |
| rx_ready_o | output | 1 | Device accepts incoming bytes |
| tx_valid_o | output | 1 | Outgoing byte valid |
| tx_data_o | output | 8 | Outgoing byte |
| tx_last_o | output | 1 | Outgoing byte is the final one of the frame |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs: rd_i and wr_i are never high in the same cycle, rx_last_i matters only together with rx_valid_i, and a control write that clears bit 0 never coincides with the final transmit data write. The bench respects all three by running bus operations strictly one at a time. It never overlaps a bus access with an incoming stream byte, except when it deliberately drives a stream byte while a frame is still waiting, so that the drop path is exercised.

// File: rtl/bytenet_pkg.sv
package bytenet_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_ID_LO    = 4'd0,
    REG_ID_HI    = 4'd1,
    REG_BUSY     = 4'd2,
    REG_RX_CNT   = 4'd3,
    REG_TX_CNT   = 4'd4,
    REG_IRQ_CTL  = 4'd5,
    REG_IRQ_INFO = 4'd6,
    REG_RX_DATA  = 4'd7,
    REG_TX_DATA  = 4'd8
  } reg_idx_e;

  localparam int unsigned IRQ_TX_BIT   = 0;
  localparam int unsigned IRQ_RX_BIT   = 1;
  localparam int unsigned IRQ_TEST_BIT = 31;

  // signature, first character in the least significant byte
  function automatic logic [63:0] dev_sig(input logic [3:0] version);
    logic [55:0] base;
    logic [63:0] sig;
    base = "BNETDEV";
    sig  = '0;
    for (int i = 0; i < 7; i++) sig[i*8 +: 8] = base[(6-i)*8 +: 8];
    sig[63:56] = 8'h30 + {4'h0, version};
    return sig;
  endfunction
endpackage

// File: rtl/bytenet_rx.sv
module bytenet_rx #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  input  logic             in_last_i,
  output logic             in_ready_o,
  input  logic             pop_i,
  input  logic             ack_i,
  output logic             avail_o,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [7:0]       head_o
);
  localparam int unsigned PTR_W  = $clog2(DEPTH);
  localparam int unsigned FILL_W = PTR_W + 1;

  logic [7:0]        mem_q [DEPTH];
  logic [FILL_W-1:0] fill_q;
  logic [PTR_W-1:0]  rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              avail_q, active_q;

  logic              accept, store, frame_end;
  logic [FILL_W-1:0] fill_nxt;

  assign accept    = in_valid_i & ~avail_q;
  assign store     = accept & (fill_q < FILL_W'(DEPTH));
  assign frame_end = accept & in_last_i;
  assign fill_nxt  = fill_q + FILL_W'(store);

  always_ff @(posedge clk_i) begin
    if (store) mem_q[fill_q[PTR_W-1:0]] <= in_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q   <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      avail_q  <= 1'b0;
      active_q <= 1'b0;
    end else if (frame_end) begin
      fill_q   <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= CNT_W'(fill_nxt);
      avail_q  <= 1'b1;
      active_q <= 1'b0;
    end else begin
      if (accept) begin
        fill_q   <= fill_nxt;
        active_q <= 1'b1;
      end
      if (pop_i && cnt_q != '0) begin
        cnt_q    <= cnt_q - 1'b1;
        rd_ptr_q <= rd_ptr_q + 1'b1;
      end
      if (ack_i) avail_q <= 1'b0;
    end
  end

  assign in_ready_o = ~avail_q;
  assign avail_o    = avail_q;
  assign active_o   = active_q;
  assign cnt_o      = cnt_q;
  assign head_o     = mem_q[rd_ptr_q];

  // R5
  rx_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  // R4
  rx_pop_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && cnt_q != '0 && !frame_end |=> cnt_q == $past(cnt_q) - 1'b1);

  // R3
  rx_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_q |=> fill_q == $past(fill_q));
endmodule

// File: rtl/bytenet_tx.sv
module bytenet_tx #(
  parameter int unsigned MAX_BYTES = 65536,
  parameter int unsigned CNT_W     = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [31:0]      load_val_i,
  input  logic             push_i,
  input  logic [7:0]       push_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic             out_last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             fire, final_byte;

  assign fire       = push_i & (cnt_q != '0);
  assign final_byte = fire & (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_last_o  <= 1'b0;
    end else begin
      if (load_i)
        cnt_q <= (load_val_i > 32'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : CNT_W'(load_val_i);
      else if (fire)
        cnt_q <= cnt_q - 1'b1;
      out_valid_o <= fire;
      out_last_o  <= final_byte;
      if (fire) out_data_o <= push_data_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = final_byte;

  // R6
  tx_emit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && cnt_q != '0 |=> out_valid_o && out_data_o == $past(push_data_i));

  // R7
  tx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !load_i && cnt_q == '0 |=> !out_valid_o && cnt_q == '0);

  // R6
  tx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_BYTES));
endmodule

// File: rtl/bytenet_irq.sv
module bytenet_irq (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        done_set_i,
  input  logic        rx_avail_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [31:0] wdata_i,
  output logic        done_o,
  output logic        test_o,
  output logic        irq_o
);
  import bytenet_pkg::*;

  logic done_q, test_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      test_q <= 1'b0;
    end else begin
      if (done_set_i)                    done_q <= 1'b1;
      else if (wr_i && wdata_i[IRQ_TX_BIT]) done_q <= 1'b0;

      if (wr_i) begin
        if (wdata_i[IRQ_TEST_BIT])   test_q <= 1'b1;
        else if (wdata_i == '0)      test_q <= 1'b0;
      end else if (rd_i) begin
        test_q <= 1'b0;
      end
    end
  end

  assign done_o = done_q;
  assign test_o = test_q;
  assign irq_o  = done_q | rx_avail_i | test_q;

  // R8
  done_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_set_i |=> done_q);

  // R8
  done_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wdata_i[IRQ_TX_BIT] && !done_set_i |=> !done_q);

  // R9
  test_rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !wr_i |=> !test_q);
endmodule

// File: rtl/bytenet_dev.sv
module bytenet_dev #(
  parameter int unsigned RX_DEPTH  = 2048,
  parameter int unsigned MAX_BYTES = 65536,
  parameter logic [3:0]  VERSION   = 4'd1,
  parameter logic [31:0] INFO_WORD = 32'h0000_0102
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_last_i,
  output logic        rx_ready_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_last_o,
  output logic        irq_o
);
  import bytenet_pkg::*;

  localparam int unsigned CNT_W = $clog2(MAX_BYTES + 1);
  localparam logic [63:0] SIG   = dev_sig(VERSION);

  logic             wr_ctl, rd_ctl, wr_txc, wr_txd, rd_rxd;
  logic             rx_avail, rx_active, tx_done_set, tx_done, test_bit;
  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic [7:0]       rx_head;

  assign wr_ctl = wr_i & (addr_i == REG_IRQ_CTL);
  assign rd_ctl = rd_i & (addr_i == REG_IRQ_CTL);
  assign wr_txc = wr_i & (addr_i == REG_TX_CNT);
  assign wr_txd = wr_i & (addr_i == REG_TX_DATA);
  assign rd_rxd = rd_i & (addr_i == REG_RX_DATA);

  bytenet_rx #(.DEPTH(RX_DEPTH), .CNT_W(CNT_W)) i_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (rx_valid_i),
    .in_data_i  (rx_data_i),
    .in_last_i  (rx_last_i),
    .in_ready_o (rx_ready_o),
    .pop_i      (rd_rxd),
    .ack_i      (wr_ctl & wdata_i[IRQ_RX_BIT]),
    .avail_o    (rx_avail),
    .active_o   (rx_active),
    .cnt_o      (rx_cnt),
    .head_o     (rx_head)
  );

  bytenet_tx #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) i_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (wr_txc),
    .load_val_i  (wdata_i),
    .push_i      (wr_txd),
    .push_data_i (wdata_i[7:0]),
    .cnt_o       (tx_cnt),
    .done_o      (tx_done_set),
    .out_valid_o (tx_valid_o),
    .out_data_o  (tx_data_o),
    .out_last_o  (tx_last_o)
  );

  bytenet_irq i_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_set_i (tx_done_set),
    .rx_avail_i (rx_avail),
    .wr_i       (wr_ctl),
    .rd_i       (rd_ctl),
    .wdata_i    (wdata_i),
    .done_o     (tx_done),
    .test_o     (test_bit),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        REG_ID_LO:    rdata_o = SIG[31:0];
        REG_ID_HI:    rdata_o = SIG[63:32];
        REG_BUSY:     rdata_o = {31'b0, rx_active | (tx_cnt != '0)};
        REG_RX_CNT:   rdata_o = 32'(rx_cnt);
        REG_TX_CNT:   rdata_o = 32'(tx_cnt);
        REG_IRQ_CTL: begin
          rdata_o[IRQ_TX_BIT]   = tx_done;
          rdata_o[IRQ_RX_BIT]   = rx_avail;
          rdata_o[IRQ_TEST_BIT] = test_bit;
        end
        REG_IRQ_INFO: rdata_o = INFO_WORD;
        REG_RX_DATA:  rdata_o = (rx_cnt != '0) ? {24'b0, rx_head} : 32'b0;
        default:      rdata_o = '0;
      endcase
    end
  end

  // R3
  rx_avail_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_avail) |-> $past(rx_valid_i && rx_last_i));

  // R11
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i > 4'd8 |-> rdata_o == '0);

  // R10
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_done && !test_bit && rx_ready_o |-> !irq_o);
endmodule

// File: tb/test_bytenet_dev.sv
`timescale 1ns/1ps
module test_bytenet_dev;
  localparam int DEPTH = 2048;
  localparam logic [31:0] INFO = 32'h0000_0102;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        tx_valid, tx_last, irq;
  logic [7:0]  tx_data;

  int n_tests = 0, n_fail = 0;

  // reference model state
  logic [7:0] m_rxq[$];
  logic [7:0] m_frame[$];
  int   m_cnt = 0, m_txc = 0;
  bit   m_avail = 0, m_done = 0, m_test = 0, m_active = 0;
  bit   e_txv = 0, e_txl = 0;
  logic [7:0] e_txd = '0;

  always #5 clk = ~clk;

  bytenet_dev i_bytenet_dev (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_last_i(rx_last), .rx_ready_o(rx_ready), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .tx_last_o(tx_last), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [3:0] a);
    case (a)
      4'd0: return 32'h5445_4E42;
      4'd1: return 32'h3156_4544;
      4'd2: return {31'b0, (m_active || m_txc != 0)};
      4'd3: return 32'(m_cnt);
      4'd4: return 32'(m_txc);
      4'd5: return {m_test, 29'b0, m_avail, m_done};
      4'd6: return INFO;
      4'd7: return (m_cnt > 0) ? {24'b0, m_rxq[0]} : 32'b0;
      default: return 32'b0;
    endcase
  endfunction

  task automatic model_step();
    bit old_avail = m_avail;
    e_txv = 0; e_txl = 0;
    if (rd && addr == 4'd7 && m_cnt > 0) begin
      void'(m_rxq.pop_front());
      m_cnt--;
    end
    if (rd && addr == 4'd5) m_test = 0;
    if (wr) begin
      case (addr)
        4'd4: m_txc = (wdata > 32'd65536) ? 65536 : int'(wdata);
        4'd8: if (m_txc > 0) begin
          e_txv = 1; e_txd = wdata[7:0]; e_txl = (m_txc == 1);
          m_txc--;
          if (m_txc == 0) m_done = 1;
        end
        4'd5: begin
          if (wdata[0]) m_done = 0;
          if (wdata[1]) m_avail = 0;
          if (wdata[31]) m_test = 1;
          else if (wdata == 0) m_test = 0;
        end
        default: ;
      endcase
    end
    if (rx_valid && !old_avail) begin
      if (m_frame.size() < DEPTH) m_frame.push_back(rx_data);
      m_active = 1;
      if (rx_last) begin
        m_rxq = m_frame;
        m_cnt = m_frame.size();
        m_avail = 1; m_active = 0;
        m_frame.delete();
      end
    end
  endtask

  // model advances at each edge, outputs compared 1 ns later
  always begin
    @(posedge clk);
    if (rst_n) model_step();
    #1;
    if (rst_n) begin
      chk("R3 rx_ready", {31'b0, rx_ready}, {31'b0, !m_avail});
      chk("R6/R7 tx_valid", {31'b0, tx_valid}, {31'b0, e_txv});
      if (e_txv) begin
        chk("R6 tx_data", {24'b0, tx_data}, {24'b0, e_txd});
        chk("R6 tx_last", {31'b0, tx_last}, {31'b0, e_txl});
      end
      chk("R10 irq", {31'b0, irq}, {31'b0, m_done | m_avail | m_test});
    end
  end

  task automatic bus_rd(logic [3:0] a, string tag, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #4; d = rdata;
    chk(tag, d, exp_rd(a));
    @(posedge clk); #2; rd = 1'b0;
  endtask

  task automatic bus_wr(logic [3:0] a, logic [31:0] v);
    @(negedge clk); wr = 1'b1; addr = a; wdata = v;
    @(posedge clk); #2; wr = 1'b0;
  endtask

  task automatic rx_send(logic [7:0] b, logic last);
    @(negedge clk); rx_valid = 1'b1; rx_data = b; rx_last = last;
    @(posedge clk); #2; rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  initial begin : watchdog
    #1_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    #22;
    chk("R10 irq in reset", {31'b0, irq}, 32'd0);
    chk("R3 ready in reset", {31'b0, rx_ready}, 32'd1);
    chk("R6 tx_valid in reset", {31'b0, tx_valid}, 32'd0);
    rst_n = 1'b1;

    // R1, R11: fixed words and unmapped space
    bus_rd(4'd0, "R1 sig low", d);  chk("R1 sig low const", d, 32'h5445_4E42);
    bus_rd(4'd1, "R1 sig high", d); chk("R1 sig high const", d, 32'h3156_4544);
    bus_rd(4'd6, "R11 info", d);    chk("R11 info const", d, INFO);
    bus_rd(4'd2, "R2 busy idle", d); chk("R2 busy idle const", d, 32'd0);
    for (int a = 9; a < 16; a++) bus_rd(4'(a), "R11 unmapped read", d);
    bus_wr(4'd0, 32'hFFFF_FFFF); bus_wr(4'd6, 32'h0); bus_wr(4'd12, 32'h1234);
    bus_wr(4'd3, 32'h55); bus_wr(4'd2, 32'h1);
    bus_rd(4'd0, "R1 sig after write", d);
    bus_rd(4'd6, "R11 info after write", d);
    bus_rd(4'd12, "R11 unmapped after write", d);
    bus_rd(4'd3, "R11 rx count after write", d); chk("R11 rx count const", d, 32'd0);

    // R2, R3, R4: five-byte frame
    rx_send(8'hA1, 1'b0);
    bus_rd(4'd2, "R2 busy mid frame", d); chk("R2 busy mid const", d, 32'd1);
    rx_send(8'hB2, 1'b0); rx_send(8'hC3, 1'b0); rx_send(8'hD4, 1'b0); rx_send(8'hE5, 1'b1);
    bus_rd(4'd3, "R3 rx count", d); chk("R3 rx count const", d, 32'd5);
    bus_rd(4'd5, "R3 rx avail", d); chk("R3 avail const", d, 32'd2);
    rx_send(8'h77, 1'b0); rx_send(8'h78, 1'b1);
    bus_rd(4'd3, "R3 blocked frame", d); chk("R3 blocked const", d, 32'd5);
    bus_rd(4'd7, "R4 data0", d); chk("R4 data0 const", d, 32'h0000_00A1);
    for (int i = 1; i < 5; i++) bus_rd(4'd7, "R4 data", d);
    chk("R4 last byte const", d, 32'h0000_00E5);
    bus_rd(4'd7, "R4 empty read", d); chk("R4 empty const", d, 32'd0);
    bus_rd(4'd3, "R4 count zero", d);
    bus_wr(4'd5, 32'h2);
    bus_rd(4'd5, "R8 rx ack", d); chk("R8 rx ack const", d, 32'd0);

    // R6, R7, R8: transmit
    bus_wr(4'd4, 32'd3);
    bus_rd(4'd2, "R2 busy tx", d); chk("R2 busy tx const", d, 32'd1);
    bus_wr(4'd8, 32'hFFFF_FF11); bus_wr(4'd8, 32'h22); bus_wr(4'd8, 32'h33);
    bus_rd(4'd4, "R6 tx count drained", d); chk("R6 drained const", d, 32'd0);
    bus_rd(4'd5, "R8 tx done", d); chk("R8 tx done const", d, 32'd1);
    bus_wr(4'd8, 32'h44);
    bus_rd(4'd4, "R7 count stays zero", d);
    bus_wr(4'd5, 32'h0);
    bus_rd(4'd5, "R8 zero write keeps", d); chk("R8 keep const", d, 32'd1);
    bus_wr(4'd5, 32'h1);
    bus_rd(4'd5, "R8 w1c", d); chk("R8 w1c const", d, 32'd0);
    bus_wr(4'd4, 32'h0001_2345);
    bus_rd(4'd4, "R6 clamp", d); chk("R6 clamp const", d, 32'd65536);
    bus_wr(4'd4, 32'd65535);
    bus_rd(4'd4, "R6 no clamp", d); chk("R6 no clamp const", d, 32'd65535);
    bus_wr(4'd4, 32'd0);

    // R9: test interrupt
    bus_wr(4'd5, 32'h8000_0000);
    bus_rd(4'd5, "R9 test set", d); chk("R9 test set const", d, 32'h8000_0000);
    bus_rd(4'd5, "R9 cleared by read", d); chk("R9 read clear const", d, 32'd0);
    bus_wr(4'd5, 32'h8000_0000); bus_wr(4'd5, 32'h1);
    chk("R9 nonzero write keeps", {31'b0, irq}, 32'd1);
    bus_wr(4'd5, 32'h0);
    chk("R9 zero write clears", {31'b0, irq}, 32'd0);

    // R5: oversize frame
    for (int i = 0; i < DEPTH + 2; i++) rx_send(8'(i) ^ 8'h5A, i == DEPTH + 1);
    bus_rd(4'd3, "R5 truncated count", d); chk("R5 count const", d, 32'(DEPTH));
    for (int i = 0; i < DEPTH; i++) bus_rd(4'd7, "R5 truncated data", d);
    chk("R5 final byte const", d, {24'b0, 8'(DEPTH - 1) ^ 8'h5A});
    bus_rd(4'd3, "R5 drained", d);
    bus_wr(4'd5, 32'h2);
    bus_rd(4'd5, "R8 final ack", d);

    repeat (3) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule